// File: doc/BRIEF.md
# Claim/Complete Interrupt Controller

This block gathers a set of level-driven interrupt sources and routes them to several target contexts (one per processor privilege level or core, as the integrator decides). Each source has a priority register. Each context has its own enable bitmap and threshold, and raises one interrupt line while it has a source it may take. Software reads a per-context claim register to take the best candidate. It later writes the same source ID back to the register to finish the service.

The register interface is a zero-wait single-beat bus: a read strobe, a write strobe, a 16-bit byte address, 32-bit write data, combinational read data and a ready flag. Every register side effect is applied at the clock edge that ends the access. The interrupt lines show the new state one edge later.

Source ID 0 is reserved and means "nothing to take". The source input vector therefore starts at bit 1. Priority values are 0 to `NLEVELS`, and priority 0 never wins. With `NLEVELS+1` a power of two (the default is 7), written priority and threshold values are folded modulo `NLEVELS+1`. For any other level count, a write above `NLEVELS` is dropped.

Top module: `icc_top`

## Requirements
- R1: After reset every priority, pending, claimed, enable and threshold bit is 0, every `irq_o` bit is 0, and every claim read returns 0.
- R2: The word at byte address 0x0000 + 4k is the priority of source k+1, for k = 0 .. NSRC-2. With the default NLEVELS = 7, a write stores the value modulo 8, and a read returns the stored value in bits [2:0].
- R3: The pending bitmap is read-only at 0x1000 + 4w, where bit b of word w is source 32w+b. A source's pending bit is set by a rising edge on its input and cleared by a falling edge. Writes to the bitmap have no effect.
- R4: Context c's enable bitmap is at 0x2000 + 0x80c + 4w, with bit b of word w enabling source 32w+b, and all 32 written bits read back. Word indexes at or above ceil(NSRC/32) read 0 and ignore writes.
- R5: Context c's threshold is at 0x4000 + 0x100c. It is filtered like a priority (modulo 8 by default).
- R6: A read of context c's claim register at 0x4004 + 0x100c returns the source with the highest priority among those that are pending, not claimed, enabled in c, and have a priority strictly above c's threshold. A tie goes to the lowest ID. If no source qualifies, the read returns 0.
- R7: A claim read that returns a nonzero ID clears that source's pending bit and sets its claimed bit. Claimed state is shared by all contexts, so no context is offered the source again until it is completed.
- R8: A write of an ID below NSRC to any claim register clears that source's claimed bit. An ID at or above NSRC is ignored, with no truncation. A completed source is offered again only after a new rising edge on its input.
- R9: `irq_o[c]` is high exactly in the cycle after one in which a claim read of context c would return a nonzero ID.
- R10: A claim read returns the winner computed from the state before the access edge. An input edge in the same cycle shows up only from the next access on.
- R11: `ready_o` is high in any cycle with `rd_i` or `wr_i`. Unmapped, unaligned or reserved addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC-1 | Source levels, bit k is source ID k (k = 1 .. NSRC-1) |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of `rd_i` |
| ready_o | output | 1 | Access accepted |
| irq_o | output | NCTX | Interrupt line per context |

## Verification
A claim read can share its cycle with an input edge, since the pending bitmap is updated from the inputs on the same clock edge that applies the claim. The bench raises a higher-priority source in the very cycle it strobes a claim read. It expects the read to return the previous winner and the next claim read to return the new source. Tie-breaking, completion of out-of-range IDs whose low bits name a live source, and the one-cycle lag of `irq_o` are judged against a register-level model in the bench.

// File: rtl/icc_pkg.sv
`timescale 1ns/1ps
package icc_pkg;
  localparam int unsigned AW         = 16;
  localparam int unsigned PRIO_BASE  = 32'h0000;
  localparam int unsigned PEND_BASE  = 32'h1000;
  localparam int unsigned EN_BASE    = 32'h2000;
  localparam int unsigned EN_STRIDE  = 32'h80;
  localparam int unsigned CTX_BASE   = 32'h4000;
  localparam int unsigned CTX_STRIDE = 32'h100;

  typedef enum logic [2:0] {
    ACC_NONE, ACC_PRIO, ACC_PEND, ACC_EN, ACC_THR, ACC_CLAIM
  } acc_kind_e;
endpackage

// File: rtl/icc_decode.sv
`timescale 1ns/1ps
module icc_decode import icc_pkg::*; #(
  parameter int unsigned NSRC   = 40,
  parameter int unsigned NCTX   = 2,
  parameter int unsigned NWORDS = 2,
  parameter int unsigned CW     = 1,
  parameter int unsigned IDW    = 6
) (
  input  logic [AW-1:0]  addr_i,
  output acc_kind_e      kind_o,
  output logic [CW-1:0]  ctx_o,
  output logic [IDW-1:0] idx_o
);
  always_comb begin
    int unsigned a, off, rel;
    a      = {16'd0, addr_i};
    kind_o = ACC_NONE;
    ctx_o  = '0;
    idx_o  = '0;
    off    = 0;
    rel    = 0;
    if (addr_i[1:0] == 2'b00) begin
      if (a >= PRIO_BASE && (a - PRIO_BASE) < (NSRC - 1) * 4) begin
        kind_o = ACC_PRIO;
        idx_o  = IDW'((a - PRIO_BASE) / 4 + 1);
      end else if (a >= PEND_BASE && (a - PEND_BASE) < NWORDS * 4) begin
        kind_o = ACC_PEND;
        idx_o  = IDW'((a - PEND_BASE) / 4);
      end else if (a >= EN_BASE && (a - EN_BASE) < NCTX * EN_STRIDE) begin
        off = a - EN_BASE;
        rel = (off % EN_STRIDE) / 4;
        if (rel < NWORDS) begin
          kind_o = ACC_EN;
          ctx_o  = CW'(off / EN_STRIDE);
          idx_o  = IDW'(rel);
        end
      end else if (a >= CTX_BASE && (a - CTX_BASE) < NCTX * CTX_STRIDE) begin
        off = a - CTX_BASE;
        rel = off % CTX_STRIDE;
        ctx_o = CW'(off / CTX_STRIDE);
        if (rel == 0)      kind_o = ACC_THR;
        else if (rel == 4) kind_o = ACC_CLAIM;
      end
    end
  end
endmodule

// File: rtl/icc_src_bank.sv
`timescale 1ns/1ps
module icc_src_bank #(
  parameter int unsigned NSRC = 40,
  parameter int unsigned PW   = 3,
  parameter int unsigned IDW  = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NSRC-1:1]          src_i,
  input  logic                     prio_we_i,
  input  logic [IDW-1:0]           prio_id_i,
  input  logic [PW-1:0]            prio_val_i,
  input  logic                     claim_i,
  input  logic [IDW-1:0]           claim_id_i,
  input  logic                     done_i,
  input  logic [IDW-1:0]           done_id_i,
  output logic [NSRC-1:0][PW-1:0]  prio_o,
  output logic [NSRC-1:0]          pend_o,
  output logic [NSRC-1:0]          claimed_o
);
  logic [NSRC-1:1] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q     <= '0;
      prio_o    <= '0;
      pend_o    <= '0;
      claimed_o <= '0;
    end else begin
      src_q        <= src_i;
      prio_o[0]    <= '0;
      pend_o[0]    <= 1'b0;
      claimed_o[0] <= 1'b0;
      for (int i = 1; i < NSRC; i++) begin
        // an input edge outranks a claim in the same cycle
        if (src_i[i] != src_q[i])
          pend_o[i] <= src_i[i];
        else if (claim_i && claim_id_i == IDW'(i))
          pend_o[i] <= 1'b0;
        if (claim_i && claim_id_i == IDW'(i))
          claimed_o[i] <= 1'b1;
        else if (done_i && done_id_i == IDW'(i))
          claimed_o[i] <= 1'b0;
        if (prio_we_i && prio_id_i == IDW'(i))
          prio_o[i] <= prio_val_i;
      end
    end
  end
endmodule

// File: rtl/icc_sel.sv
`timescale 1ns/1ps
module icc_sel #(
  parameter int unsigned NSRC = 40,
  parameter int unsigned PW   = 3,
  parameter int unsigned IDW  = 6
) (
  input  logic [NSRC-1:0]          cand_i,
  input  logic [NSRC-1:0][PW-1:0]  prio_i,
  input  logic [PW-1:0]            thr_i,
  output logic [IDW-1:0]           id_o
);
  always_comb begin
    logic [PW-1:0] best;
    best = thr_i;
    id_o = '0;
    // ascending scan with strict compare keeps the lowest ID on ties
    for (int i = 0; i < NSRC; i++) begin
      if (cand_i[i] && prio_i[i] > best) begin
        best = prio_i[i];
        id_o = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/icc_ctx.sv
`timescale 1ns/1ps
module icc_ctx #(
  parameter int unsigned NSRC   = 40,
  parameter int unsigned NWORDS = 2,
  parameter int unsigned PW     = 3,
  parameter int unsigned IDW    = 6,
  localparam int unsigned BW    = NWORDS * 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_we_i,
  input  logic [IDW-1:0]           en_word_i,
  input  logic                     thr_we_i,
  input  logic [31:0]              wdata_i,
  input  logic [PW-1:0]            thr_val_i,
  input  logic [NSRC-1:0]          pend_i,
  input  logic [NSRC-1:0]          claimed_i,
  input  logic [NSRC-1:0][PW-1:0]  prio_i,
  output logic [BW-1:0]            en_o,
  output logic [PW-1:0]            thr_o,
  output logic [IDW-1:0]           best_o,
  output logic                     irq_o
);
  logic [NSRC-1:0] cand;

  assign cand = pend_i & ~claimed_i & en_o[NSRC-1:0];

  icc_sel #(.NSRC(NSRC), .PW(PW), .IDW(IDW)) u_sel (
    .cand_i (cand),
    .prio_i (prio_i),
    .thr_i  (thr_o),
    .id_o   (best_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= '0;
      thr_o <= '0;
      irq_o <= 1'b0;
    end else begin
      if (en_we_i) begin
        for (int w = 0; w < NWORDS; w++)
          if (en_word_i == IDW'(w)) en_o[w*32 +: 32] <= wdata_i;
      end
      if (thr_we_i) thr_o <= thr_val_i;
      irq_o <= (best_o != '0);
    end
  end
endmodule

// File: rtl/icc_top.sv
`timescale 1ns/1ps
module icc_top import icc_pkg::*; #(
  parameter int unsigned NSRC    = 40,
  parameter int unsigned NCTX    = 2,
  parameter int unsigned NLEVELS = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:1]   src_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ready_o,
  output logic [NCTX-1:0]   irq_o
);
  localparam int unsigned NWORDS = (NSRC + 31) / 32;
  localparam int unsigned BW     = NWORDS * 32;
  localparam int unsigned PW     = $clog2(NLEVELS + 1);
  localparam int unsigned IDW    = $clog2(NSRC);
  localparam int unsigned CW     = (NCTX > 1) ? $clog2(NCTX) : 1;
  localparam bit          POW2   = (((NLEVELS + 1) & NLEVELS) == 0);

  acc_kind_e                kind;
  logic [CW-1:0]            ctx;
  logic [IDW-1:0]           idx;
  logic                     legal_ok;
  logic [PW-1:0]            legal_val;
  logic [NSRC-1:0][PW-1:0]  prio;
  logic [NSRC-1:0]          pend, claimed;
  logic [NCTX-1:0][IDW-1:0] best;
  logic [NCTX-1:0][PW-1:0]  thr;
  logic [NCTX-1:0][BW-1:0]  en_all;
  logic [IDW-1:0]           sel_id;
  logic                     claim_v, done_v, prio_we;
  logic [IDW-1:0]           done_id;
  logic [BW-1:0]            pend_bits;

  icc_decode #(.NSRC(NSRC), .NCTX(NCTX), .NWORDS(NWORDS), .CW(CW), .IDW(IDW)) u_dec (
    .addr_i (addr_i),
    .kind_o (kind),
    .ctx_o  (ctx),
    .idx_o  (idx)
  );

  // write-any-read-legal filter shared by priority and threshold
  always_comb begin
    if (POW2) begin
      legal_ok  = 1'b1;
      legal_val = PW'(wdata_i % (NLEVELS + 1));
    end else begin
      legal_ok  = (wdata_i <= NLEVELS);
      legal_val = PW'(wdata_i);
    end
  end

  assign sel_id  = best[ctx];
  assign claim_v = rd_i && (kind == ACC_CLAIM) && (sel_id != '0);
  assign done_v  = wr_i && (kind == ACC_CLAIM) && (wdata_i < NSRC);
  assign done_id = IDW'(wdata_i);
  assign prio_we = wr_i && (kind == ACC_PRIO) && legal_ok;

  icc_src_bank #(.NSRC(NSRC), .PW(PW), .IDW(IDW)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .prio_we_i  (prio_we),
    .prio_id_i  (idx),
    .prio_val_i (legal_val),
    .claim_i    (claim_v),
    .claim_id_i (sel_id),
    .done_i     (done_v),
    .done_id_i  (done_id),
    .prio_o     (prio),
    .pend_o     (pend),
    .claimed_o  (claimed)
  );

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic en_we, thr_we;
    assign en_we  = wr_i && (kind == ACC_EN)  && (ctx == CW'(c));
    assign thr_we = wr_i && (kind == ACC_THR) && (ctx == CW'(c)) && legal_ok;

    icc_ctx #(.NSRC(NSRC), .NWORDS(NWORDS), .PW(PW), .IDW(IDW)) u_ctx (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_we_i   (en_we),
      .en_word_i (idx),
      .thr_we_i  (thr_we),
      .wdata_i   (wdata_i),
      .thr_val_i (legal_val),
      .pend_i    (pend),
      .claimed_i (claimed),
      .prio_i    (prio),
      .en_o      (en_all[c]),
      .thr_o     (thr[c]),
      .best_o    (best[c]),
      .irq_o     (irq_o[c])
    );
  end

  assign pend_bits = BW'(pend);
  assign ready_o   = rd_i | wr_i;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (kind)
        ACC_PRIO:  rdata_o = 32'(prio[idx]);
        ACC_PEND:  for (int w = 0; w < NWORDS; w++)
                     if (idx == IDW'(w)) rdata_o = pend_bits[w*32 +: 32];
        ACC_EN:    for (int w = 0; w < NWORDS; w++)
                     if (idx == IDW'(w)) rdata_o = en_all[ctx][w*32 +: 32];
        ACC_THR:   rdata_o = 32'(thr[ctx]);
        ACC_CLAIM: rdata_o = 32'(sel_id);
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/icc_chk.sv
`timescale 1ns/1ps
module icc_chk #(
  parameter int unsigned NSRC = 40,
  parameter int unsigned NCTX = 2,
  parameter int unsigned PW   = 3,
  parameter int unsigned IDW  = 6
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NCTX-1:0]          irq_i,
  input logic                     claim_v_i,
  input logic [IDW-1:0]           claim_id_i,
  input logic                     done_v_i,
  input logic [IDW-1:0]           done_id_i,
  input logic [NSRC-1:0]          pend_i,
  input logic [NSRC-1:0]          claimed_i,
  input logic [NSRC-1:0][PW-1:0]  prio_i,
  input logic [NCTX-1:0][PW-1:0]  thr_i,
  input logic [NCTX-1:0][IDW-1:0] best_i
);
  assert_claim_marks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_v_i |=> (claimed_i[$past(claim_id_i)] && !pend_i[$past(claim_id_i)]));

  assert_complete_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_v_i && !claim_v_i) |=> !claimed_i[$past(done_id_i)]);

  for (genvar c = 0; c < NCTX; c++) begin : g_chk
    assert_no_reoffer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (best_i[c] != '0) |-> !claimed_i[best_i[c]]);

    assert_above_threshold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (best_i[c] != '0) |-> (prio_i[best_i[c]] > thr_i[c]));

    assert_irq_lag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[c] == ($past(best_i[c]) != '0));
  end
endmodule

bind icc_top icc_chk #(.NSRC(NSRC), .NCTX(NCTX), .PW(PW), .IDW(IDW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_i      (irq_o),
  .claim_v_i  (claim_v),
  .claim_id_i (sel_id),
  .done_v_i   (done_v),
  .done_id_i  (done_id),
  .pend_i     (pend),
  .claimed_i  (claimed),
  .prio_i     (prio),
  .thr_i      (thr),
  .best_i     (best)
);

// File: tb/tb_icc_top.sv
`timescale 1ns/1ps
module tb_icc_top;
  localparam int unsigned NSRC = 40, NCTX = 2, NLEVELS = 7, NW = 2;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:1] src = '0;
  logic            rd = 1'b0, wr = 1'b0;
  logic [15:0]     addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            ready;
  logic [NCTX-1:0] irq;

  always #10 clk = ~clk;

  icc_top #(.NSRC(NSRC), .NCTX(NCTX), .NLEVELS(NLEVELS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // register-level model
  logic [NSRC-1:0]    m_pend = '0, m_claim = '0;
  int                 m_prio[NSRC] = '{default: 0};
  logic [NW*32-1:0]   m_en[NCTX] = '{default: '0};
  int                 m_thr[NCTX] = '{default: 0};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int m_best(input int c);
    int b = m_thr[c], id = 0;
    for (int i = 0; i < NSRC; i++)
      if (m_pend[i] && !m_claim[i] && m_en[c][i] && m_prio[i] > b) begin
        b = m_prio[i]; id = i;
      end
    return id;
  endfunction

  function automatic logic [31:0] m_word(input int w);
    logic [NW*32-1:0] v = '0;
    v[NSRC-1:0] = m_pend;
    return v[w*32 +: 32];
  endfunction

  // monitor: pops expected read data
  initial forever begin
    @(negedge clk); #5;
    if (rd) begin
      check("R11 ready on read", {31'd0, ready}, 32'd1);
      if (exp_q.size() == 0) check("scoreboard underrun", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic bus_rd(input logic [15:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic set_src(input int i, input logic v);
    @(negedge clk);
    if (src[i] != v) m_pend[i] = v;
    src[i] = v;
  endtask

  task automatic wr_prio(input int id, input int v);
    bus_wr(16'((id - 1) * 4), 32'(v));
    m_prio[id] = v % (NLEVELS + 1);
  endtask

  task automatic wr_en(input int c, input int w, input logic [31:0] v);
    bus_wr(16'(32'h2000 + c * 128 + w * 4), v);
    if (w < NW) m_en[c][w*32 +: 32] = v;
  endtask

  task automatic wr_thr(input int c, input int v);
    bus_wr(16'(32'h4000 + c * 256), 32'(v));
    m_thr[c] = v % (NLEVELS + 1);
  endtask

  task automatic complete(input int c, input int id);
    bus_wr(16'(32'h4004 + c * 256), 32'(id));
    if (id < NSRC) m_claim[id] = 1'b0;
  endtask

  task automatic claim(input int c, input string t);
    int e = m_best(c);
    bus_rd(16'(32'h4004 + c * 256), 32'(e), t);
    if (e != 0) begin m_pend[e] = 1'b0; m_claim[e] = 1'b1; end
  endtask

  // claim read with an input edge in the same cycle
  task automatic claim_edge(input int c, input int i, input logic v, input string t);
    int e = m_best(c);
    @(negedge clk);
    exp_q.push_back(32'(e)); tag_q.push_back(t);
    addr = 16'(32'h4004 + c * 256); rd = 1'b1;
    if (src[i] != v) m_pend[i] = v;
    src[i] = v;
    @(negedge clk);
    rd = 1'b0;
    if (e != 0) begin m_pend[e] = 1'b0; m_claim[e] = 1'b1; end
  endtask

  task automatic chk_irq(input string t);
    logic [NCTX-1:0] e;
    for (int c = 0; c < NCTX; c++) e[c] = (m_best(c) != 0);
    @(negedge clk); @(negedge clk); #5;
    check(t, 32'(irq), 32'(e));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq("R1 irq after reset");
    bus_rd(16'h0000, 0, "R1 priority reset");
    bus_rd(16'h1000, 0, "R1 pending reset");
    bus_rd(16'h2000, 0, "R1 enable reset");
    bus_rd(16'h4000, 0, "R1 threshold reset");
    claim(0, "R1 claim reset");
    // R2 priorities
    wr_prio(3, 5);   bus_rd(16'h0008, 5, "R2 priority src3");
    wr_prio(5, 13);  bus_rd(16'h0010, 5, "R2 modulo fold");
    wr_prio(39, 15); bus_rd(16'h0098, 7, "R2 last source");
    bus_wr(16'h009C, 3); bus_rd(16'h009C, 0, "R11 past priority region");
    // R3 pending
    set_src(3, 1); set_src(33, 1);
    bus_rd(16'h1000, m_word(0), "R3 pending word0");
    bus_rd(16'h1004, m_word(1), "R3 pending word1");
    bus_wr(16'h1000, 32'hFFFF_FFFF);
    bus_rd(16'h1000, m_word(0), "R3 pending write ignored");
    // R4 enables
    wr_en(0, 0, 32'hFFFF_FFFF); wr_en(0, 1, 32'h0000_00FF);
    bus_rd(16'h2000, 32'hFFFF_FFFF, "R4 enable word0");
    bus_rd(16'h2004, 32'h0000_00FF, "R4 enable word1");
    wr_en(0, 2, 32'h1234);
    bus_rd(16'h2008, 0, "R4 word beyond bitmap");
    bus_rd(16'h2080, 0, "R4 ctx1 enable untouched");
    chk_irq("R9 irq raised ctx0 only");
    // R5 threshold
    wr_thr(0, 6); bus_rd(16'h4000, 6, "R5 threshold");
    claim(0, "R6 masked by threshold");
    chk_irq("R9 irq dropped by threshold");
    wr_thr(0, 9); bus_rd(16'h4000, 1, "R5 threshold fold");
    // R6/R7 tie and ordering
    wr_prio(33, 5);
    claim(0, "R6 tie lowest id");
    claim(0, "R7 next after claim");
    claim(0, "R7 nothing left");
    bus_rd(16'h1000, m_word(0), "R7 pending cleared");
    chk_irq("R9 irq low after claims");
    // R8 completion
    complete(0, 3);
    claim(0, "R8 no reoffer without edge");
    set_src(33, 0); set_src(33, 1);
    claim(0, "R7 claimed still masked");
    complete(0, 97);
    claim(0, "R8 out-of-range id ignored");
    complete(0, 33);
    claim(0, "R8 reoffer after complete");
    complete(0, 33);
    // R6 priority order
    wr_prio(7, 2); wr_prio(20, 6);
    set_src(7, 1); set_src(20, 1);
    claim(0, "R6 highest first");
    claim(0, "R6 lower second");
    complete(0, 20); complete(0, 7);
    // R10 same-cycle edge
    set_src(7, 0); set_src(7, 1);
    wr_prio(12, 7);
    claim_edge(0, 12, 1'b1, "R10 old winner returned");
    claim(0, "R10 new source next");
    complete(0, 7); complete(0, 12);
    // second context
    wr_prio(9, 4); wr_en(1, 0, 32'h0000_0200);
    set_src(9, 1);
    chk_irq("R9 both contexts");
    claim(1, "R7 ctx1 claim");
    claim(0, "R7 shared claimed state");
    complete(1, 9);
    // R11 unmapped
    bus_rd(16'h3000, 0, "R11 unmapped read");
    bus_rd(16'h0002, 0, "R11 unaligned read");
    bus_wr(16'h0009, 7);
    bus_rd(16'h0008, 32'(m_prio[3]), "R11 unaligned write ignored");
    bus_rd(16'h4008, 0, "R11 reserved ctx offset");
    // R3 falling edge
    set_src(25, 1); bus_rd(16'h1000, m_word(0), "R3 rising sets");
    set_src(25, 0); bus_rd(16'h1000, m_word(0), "R3 falling clears");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("scoreboard leftover", 32'(exp_q.size()), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired, requirements R1..R11 unfinished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule